// File: doc/BRIEF.md
# Trellis Path Decoder with Register-Exchange Survivors

This block turns one terminated trellis codeword back into 32 user bits. A demodulator upstream supplies, once per trellis step, a 6-bit cost for each of the eight four-dimensional signal subsets and a 5-bit point decision for each subset. The point decision is the best point inside that subset. The decoder keeps one accumulated path metric and one survivor register per trellis state. At every accepted step all eight states run add-compare-select at the same time. The winning branch's record is shifted into the survivor register, so no traceback pass is needed after the last step.

A read starts with a `start_i` pulse. That pulse arms the path metrics: state 0 gets zero and every other state gets the saturated maximum. Five `step_i` strobes follow, each carrying one step's metrics and decisions. The clock edge that accepts the fifth step raises `done_o`, and from then on `data_o` holds the decoded word, read from the state-0 survivor with the three termination bits removed. The word stays until the next `start_i`.

The controller is a three-state machine. `DEC_IDLE` waits after reset. `DEC_RUN` accepts steps. `DEC_DONE` holds the result. The transitions are:
- "arm": `DEC_IDLE` to `DEC_RUN` on start.
- "rearm": `DEC_RUN` to `DEC_RUN` on start, which discards a partial block.
- "finish": `DEC_RUN` to `DEC_DONE` when the fifth step is accepted.
- "next block": `DEC_DONE` to `DEC_RUN` on start.

Top module: `tcmdec_top`

## Requirements
- R1: After reset `done_o` is 0 and `data_o` is all zeros. `data_o` is all zeros whenever `done_o` is 0.
- R2: A `start_i` pulse clears `done_o` at the next edge and discards any partly decoded block. It also sets the state-0 path metric to 0 and every other state's path metric to 511.
- R3: `done_o` rises at the edge that accepts the fifth step after `start_i`, is still 0 after the fourth, and stays 1 until the next `start_i`.
- R4: The trellis has 8 states, and the 2-bit coded input u moves state s to {s[0], u[1], u[0]}. The branch uses subset index {u[1], u[0]^s[0], s[2]^s[1]}, and subset k's metric sits at `bm_i[6k+5:6k]` and its decision at `pd_i[5k+4:5k]`. For a terminated codeword whose true subset has metric 0 and every other subset a nonzero metric, `data_o` equals the encoded data.
- R5: Each step's 7-bit record is {u[1:0], decision[4:0]}, and the records form a 35-bit word W with step j at W[7j+6:7j]. Bits W[26], W[33] and W[34] are the zero tail bits. `data_o` = {W[32:27], W[25:0]}.
- R6: When every step's true subset costs strictly less than all other subsets of that step, `data_o` equals the encoded data.
- R7: On equal accumulated costs the predecessor with the lowest state number wins. With all metrics equal, `data_o` is built from records {00, decision of subset 0}.
- R8: Path metrics are 9 bits and saturate at 511 instead of wrapping. After the first step, states 4 to 7 hold 511, and a block with step metrics of 62 and 63 decodes correctly.
- R9: `step_i` has no effect in `DEC_IDLE` or `DEC_DONE`, nor in a cycle with `start_i` high. Such a strobe neither counts as a step nor changes `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms decoding of a new codeword |
| step_i | input | 1 | One trellis step's metrics and decisions are valid |
| bm_i | input | 48 | Eight 6-bit subset metrics, subset k at bits 6k+5:6k |
| pd_i | input | 40 | Eight 5-bit point decisions, subset k at bits 5k+4:5k |
| data_o | output | 32 | Decoded user bits, zero while not done |
| done_o | output | 1 | Decoded word is valid |

## Verification
The checker counts accepted steps from the ports. Its count assumes that `start_i` outranks `step_i` in the same cycle and that reset comes before the first start. Its saturation property looks only at the step right after a start, when states 4 to 7 can have no finite predecessor, so it holds for any metric values the 6-bit port can carry. The bench always ends its codewords with the three zero tail bits, so the true path finishes in state 0. For every decode check it keeps the true subset strictly cheapest at each step, or makes all subsets equal for the tie case, so every expected word is fixed by the requirements alone.

// File: rtl/tcmdec_pkg.sv
`timescale 1ns/1ps
package tcmdec_pkg;

    localparam int ST_BITS  = 3;
    localparam int N_STATES = 1 << ST_BITS;
    localparam int CIN_W    = 2;
    localparam int N_PRED   = 1 << CIN_W;
    localparam int PT_W     = 5;
    localparam int REC_W    = CIN_W + PT_W;
    localparam int N_TAIL   = 3;

    typedef enum logic [1:0] {
        DEC_IDLE = 2'd0,
        DEC_RUN  = 2'd1,
        DEC_DONE = 2'd2
    } dec_state_e;

    // subset chosen by a branch leaving state pred on coded input cin
    function automatic logic [ST_BITS-1:0] subset_of(input logic [ST_BITS-1:0] pred,
                                                     input logic [CIN_W-1:0]   cin);
        return {cin[1], cin[0] ^ pred[0], pred[2] ^ pred[1]};
    endfunction

endpackage

// File: rtl/tcmdec_ctrl.sv
`timescale 1ns/1ps
module tcmdec_ctrl
    import tcmdec_pkg::*;
#(
    parameter  int N_STEPS = 5,
    localparam int CNT_W   = $clog2(N_STEPS + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic step_i,
    output logic init_o,
    output logic upd_o,
    output logic done_o
);

    dec_state_e       st_q;
    dec_state_e       st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_step;

    assign last_step = (cnt_q == CNT_W'(N_STEPS - 1));

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= DEC_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // accepted-step counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= '0;
        end else if (upd_o) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DEC_IDLE: if (start_i) st_d = DEC_RUN;                 // arm
            DEC_RUN: begin
                if (start_i)                  st_d = DEC_RUN;      // rearm
                else if (step_i && last_step) st_d = DEC_DONE;     // finish
            end
            DEC_DONE: if (start_i) st_d = DEC_RUN;                 // next block
            default:  st_d = DEC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        init_o = start_i;
        upd_o  = 1'b0;
        done_o = 1'b0;
        unique case (st_q)
            DEC_IDLE: ;
            DEC_RUN:  upd_o  = step_i && !start_i;
            DEC_DONE: done_o = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/tcmdec_acs.sv
`timescale 1ns/1ps
module tcmdec_acs #(
    parameter  int PM_W  = 9,
    parameter  int BM_W  = 6,
    parameter  int N_IN  = 4,
    localparam int SEL_W = $clog2(N_IN)
) (
    input  logic [N_IN*PM_W-1:0] pm_i,
    input  logic [N_IN*BM_W-1:0] bm_i,
    output logic [SEL_W-1:0]     sel_o,
    output logic [PM_W-1:0]      pm_o
);

    logic [PM_W-1:0] cand [N_IN];

    // saturating add per incoming branch
    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_add
            logic [PM_W:0] sum;
            assign sum = {1'b0, pm_i[i*PM_W +: PM_W]}
                       + {{(PM_W + 1 - BM_W){1'b0}}, bm_i[i*BM_W +: BM_W]};
            assign cand[i] = sum[PM_W] ? {PM_W{1'b1}} : sum[PM_W-1:0];
        end
    endgenerate

    // strict-less scan: lowest index keeps a tie
    always_comb begin
        pm_o  = cand[0];
        sel_o = '0;
        for (int i = 1; i < N_IN; i++) begin
            if (cand[i] < pm_o) begin
                pm_o  = cand[i];
                sel_o = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/tcmdec_slice.sv
`timescale 1ns/1ps
module tcmdec_slice
    import tcmdec_pkg::*;
#(
    parameter  int ST     = 0,
    parameter  int PM_W   = 9,
    parameter  int BM_W   = 6,
    parameter  int SURV_W = 35,
    localparam int KEEP_W = SURV_W - REC_W
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       init_i,
    input  logic                       upd_i,
    input  logic [N_PRED*PM_W-1:0]     pred_pm_i,
    input  logic [N_PRED*KEEP_W-1:0]   pred_surv_i,
    input  logic [N_STATES*BM_W-1:0]   bm_i,
    input  logic [N_STATES*PT_W-1:0]   pd_i,
    output logic [PM_W-1:0]            pm_o,
    output logic [SURV_W-1:0]          surv_o
);

    localparam logic [ST_BITS-1:0] ST_CODE = ST_BITS'(ST);
    localparam logic [CIN_W-1:0]   CIN     = ST_CODE[CIN_W-1:0];
    localparam logic [PM_W-1:0]    PM_INIT = (ST == 0) ? '0 : {PM_W{1'b1}};

    logic [N_PRED*BM_W-1:0]  br_bm;
    logic [PT_W-1:0]         br_pt [N_PRED];
    logic [$clog2(N_PRED)-1:0] win;
    logic [PM_W-1:0]         pm_new;
    logic [SURV_W-1:0]       surv_new;

    // branch subsets: predecessor i is {i, ST[2]}
    always_comb begin
        for (int i = 0; i < N_PRED; i++) begin
            logic [ST_BITS-1:0] pred;
            logic [ST_BITS-1:0] sub;
            pred = {CIN_W'(i), ST_CODE[ST_BITS-1]};
            sub  = subset_of(pred, CIN);
            br_bm[i*BM_W +: BM_W] = bm_i[int'(sub)*BM_W +: BM_W];
            br_pt[i]              = pd_i[int'(sub)*PT_W +: PT_W];
        end
    end

    tcmdec_acs #(
        .PM_W (PM_W),
        .BM_W (BM_W),
        .N_IN (N_PRED)
    ) u_acs (
        .pm_i  (pred_pm_i),
        .bm_i  (br_bm),
        .sel_o (win),
        .pm_o  (pm_new)
    );

    assign surv_new = {CIN, br_pt[win], pred_surv_i[int'(win)*KEEP_W +: KEEP_W]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pm_o   <= PM_INIT;
            surv_o <= '0;
        end else if (init_i) begin
            pm_o   <= PM_INIT;
            surv_o <= '0;
        end else if (upd_i) begin
            pm_o   <= pm_new;
            surv_o <= surv_new;
        end
    end

endmodule

// File: rtl/tcmdec_top.sv
`timescale 1ns/1ps
module tcmdec_top
    import tcmdec_pkg::*;
#(
    parameter  int BM_W     = 6,
    parameter  int PM_W     = 9,
    parameter  int N_STEPS  = 5,
    localparam int SURV_W   = N_STEPS * REC_W,
    localparam int DATA_W   = SURV_W - N_TAIL,
    localparam int TAIL_POS = (N_STEPS - 2) * REC_W + PT_W
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     start_i,
    input  logic                     step_i,
    input  logic [N_STATES*BM_W-1:0] bm_i,
    input  logic [N_STATES*PT_W-1:0] pd_i,
    output logic [DATA_W-1:0]        data_o,
    output logic                     done_o
);

    localparam int KEEP_W = SURV_W - REC_W;

    logic                     init;
    logic                     upd;
    logic [N_STATES*PM_W-1:0] pm_flat;
    logic [SURV_W-1:0]        surv [N_STATES];
    logic [N_STATES*REC_W-1:0] unused_low;

    tcmdec_ctrl #(
        .N_STEPS (N_STEPS)
    ) u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .step_i  (step_i),
        .init_o  (init),
        .upd_o   (upd),
        .done_o  (done_o)
    );

    generate
        for (genvar s = 0; s < N_STATES; s++) begin : g_state
            logic [N_PRED*PM_W-1:0]   pred_pm;
            logic [N_PRED*KEEP_W-1:0] pred_surv;

            for (genvar i = 0; i < N_PRED; i++) begin : g_pred
                localparam int PRED = i * 2 + ((s >> (ST_BITS - 1)) & 1);
                assign pred_pm[i*PM_W +: PM_W]       = pm_flat[PRED*PM_W +: PM_W];
                assign pred_surv[i*KEEP_W +: KEEP_W] = surv[PRED][SURV_W-1:REC_W];
            end

            tcmdec_slice #(
                .ST     (s),
                .PM_W   (PM_W),
                .BM_W   (BM_W),
                .SURV_W (SURV_W)
            ) u_slice (
                .clk_i       (clk_i),
                .rst_ni      (rst_ni),
                .init_i      (init),
                .upd_i       (upd),
                .pred_pm_i   (pred_pm),
                .pred_surv_i (pred_surv),
                .bm_i        (bm_i),
                .pd_i        (pd_i),
                .pm_o        (pm_flat[s*PM_W +: PM_W]),
                .surv_o      (surv[s])
            );

            assign unused_low[s*REC_W +: REC_W] = surv[s][REC_W-1:0];
        end
    endgenerate

    // drop the two top tail bits and the one inside the second-to-last record
    assign data_o = done_o ? {surv[0][SURV_W-N_TAIL:TAIL_POS+1], surv[0][TAIL_POS-1:0]}
                           : '0;

endmodule

// File: rtl/tcmdec_chk.sv
`timescale 1ns/1ps
module tcmdec_chk #(
    parameter  int PM_W    = 9,
    parameter  int N_STEPS = 5,
    parameter  int DATA_W  = 32,
    localparam int CNT_W   = $clog2(N_STEPS + 1)
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                start_i,
    input logic                step_i,
    input logic                done_o,
    input logic [DATA_W-1:0]   data_o,
    input logic [8*PM_W-1:0]   pm_flat
);

    localparam logic [PM_W-1:0] PM_MAX = {PM_W{1'b1}};

    logic             active;
    logic [CNT_W-1:0] seen;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            active <= 1'b0;
            seen   <= '0;
        end else if (start_i) begin
            active <= 1'b1;
            seen   <= '0;
        end else if (active && step_i) begin
            seen <= seen + CNT_W'(1);
            if (seen == CNT_W'(N_STEPS - 1)) active <= 1'b0;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> data_o == '0);                                              // R1

    AST_START_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> !done_o && pm_flat[0 +: PM_W] == '0
                            && pm_flat[PM_W +: PM_W] == PM_MAX);                // R2

    AST_DONE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> seen == CNT_W'(N_STEPS) && !active);                  // R3

    AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && !start_i |=> done_o);                                         // R3

    AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active && step_i && !start_i && seen == '0
        |=> pm_flat[4*PM_W +: PM_W] == PM_MAX && pm_flat[5*PM_W +: PM_W] == PM_MAX
         && pm_flat[6*PM_W +: PM_W] == PM_MAX && pm_flat[7*PM_W +: PM_W] == PM_MAX); // R8

    AST_DONE_IGNORES_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && step_i && !start_i |=> done_o && $stable(data_o));            // R9

endmodule

bind tcmdec_top tcmdec_chk #(
    .PM_W    (PM_W),
    .N_STEPS (N_STEPS),
    .DATA_W  (DATA_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .step_i  (step_i),
    .done_o  (done_o),
    .data_o  (data_o),
    .pm_flat (pm_flat)
);

// File: tb/tb_tcmdec_top.sv
`timescale 1ns/1ps
module tb_tcmdec_top;

    logic        clk;
    logic        rst_ni;
    logic        start_i;
    logic        step_i;
    logic [47:0] bm_i;
    logic [39:0] pd_i;
    logic [31:0] data_o;
    logic        done_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    tcmdec_top dut (
        .clk_i   (clk),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .step_i  (step_i),
        .bm_i    (bm_i),
        .pd_i    (pd_i),
        .data_o  (data_o),
        .done_o  (done_o)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // {data, true-subset metric, noise seed, expected word}
    localparam logic [77:0] VEC [6] = '{
        {32'h0000_0000, 6'd0,  8'd0,  32'h0000_0000},
        {32'hFFFF_FFFF, 6'd0,  8'd0,  32'hFFFF_FFFF},
        {32'hA5C3_1E7B, 6'd0,  8'd9,  32'hA5C3_1E7B},
        {32'h1234_5678, 6'd3,  8'd21, 32'h1234_5678},
        {32'hDEAD_BEEF, 6'd40, 8'd77, 32'hDEAD_BEEF},
        {32'h8000_0001, 6'd62, 8'd5,  32'h8000_0001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [34:0] place(input logic [31:0] d);
        return {2'b00, d[31:26], 1'b0, d[25:0]};
    endfunction

    task automatic do_step(input logic [47:0] bmv, input logic [39:0] pdv);
        step_i = 1'b1;
        bm_i   = bmv;
        pd_i   = pdv;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    task automatic pulse_start();
        step_i  = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // encode d and send n_steps steps; true subset costs base, others more
    task automatic send_coded(input logic [31:0] d, input int base, input int seed,
                              input int n_steps);
        logic [34:0] w;
        logic [2:0]  s;
        w = place(d);
        s = 3'd0;
        for (int j = 0; j < n_steps; j++) begin
            logic [1:0]  u;
            logic [4:0]  p;
            logic [2:0]  sub;
            logic [47:0] bmv;
            logic [39:0] pdv;
            u   = w[7*j+5 +: 2];
            p   = w[7*j +: 5];
            sub = {u[1], u[0] ^ s[0], s[2] ^ s[1]};
            for (int k = 0; k < 8; k++) begin
                int v;
                if (k == int'(sub)) begin
                    bmv[k*6 +: 6] = 6'(base);
                    pdv[k*5 +: 5] = p;
                end else begin
                    v = base + 1 + ((seed == 0) ? 0 : ((seed + j*7 + k*5) % 13));
                    if (v > 63) v = 63;
                    bmv[k*6 +: 6] = 6'(v);
                    pdv[k*5 +: 5] = 5'(seed*5 + k*11 + j*3);
                end
            end
            s = {s[0], u};
            do_step(bmv, pdv);
            if (j == 3) check("R3 done low after four steps", {31'd0, done_o}, 32'd0);
        end
    endtask

    initial begin
        start_i = 1'b0;
        step_i  = 1'b0;
        bm_i    = '0;
        pd_i    = '0;
        rst_ni  = 1'b0;
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);

        check("R1 reset done", {31'd0, done_o}, 32'd0);
        check("R1 reset data", data_o, 32'd0);

        // strobe before any start is ignored
        do_step('0, '1);
        check("R9 idle strobe done", {31'd0, done_o}, 32'd0);
        check("R9 idle strobe data", data_o, 32'd0);

        // table of codewords: R4/R5 clean, R6 noisy, R8 near-saturation
        for (int v = 0; v < 6; v++) begin
            logic [31:0] d;
            logic [5:0]  b;
            logic [7:0]  sd;
            logic [31:0] e;
            {d, b, sd, e} = VEC[v];
            pulse_start();
            send_coded(d, int'(b), int'(sd), 5);
            check("R3 done after five steps", {31'd0, done_o}, 32'd1);
            if (v < 2)       check("R4 R5 clean decode", data_o, e);
            else if (v < 5)  check("R6 noisy decode", data_o, e);
            else             check("R8 saturating decode", data_o, e);
        end

        // done holds and a strobe in DONE changes nothing
        @(negedge clk);
        @(negedge clk);
        check("R3 done held", {31'd0, done_o}, 32'd1);
        do_step('0, '1);
        check("R9 strobe after done keeps done", {31'd0, done_o}, 32'd1);
        check("R9 strobe after done keeps data", data_o, 32'h8000_0001);

        // start clears done
        pulse_start();
        check("R2 start clears done", {31'd0, done_o}, 32'd0);
        check("R1 data zero while not done", data_o, 32'd0);

        // equal metrics everywhere: lowest predecessor wins
        begin
            logic [34:0] w;
            for (int j = 0; j < 5; j++) begin
                logic [39:0] pdv;
                for (int k = 0; k < 8; k++) pdv[k*5 +: 5] = 5'(j*9 + k*13 + 3);
                w[7*j +: 7] = {2'b00, pdv[4:0]};
                do_step({8{6'd7}}, pdv);
            end
            check("R7 tie picks lowest predecessor", data_o, {w[32:27], w[25:0]});
        end

        // restart in the middle of a block
        pulse_start();
        send_coded(32'h0F0F_3C3C, 0, 4, 2);
        pulse_start();
        send_coded(32'h7654_3210, 1, 33, 5);
        check("R2 restart discards partial block", data_o, 32'h7654_3210);

        // start and step together: step is not counted
        start_i = 1'b1;
        step_i  = 1'b1;
        bm_i    = '0;
        pd_i    = '1;
        @(negedge clk);
        start_i = 1'b0;
        step_i  = 1'b0;
        send_coded(32'hC0FF_EE11, 2, 50, 5);
        check("R9 step with start ignored", data_o, 32'hC0FF_EE11);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule